// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from memory to a MAC. Software builds a list of four-word transmit descriptors in memory. The list is either a ring of consecutive entries or a set of entries joined by next pointers. Software then starts the engine through a small register port. The engine reads each descriptor over a word-wide memory master port and checks that the engine owns it. It then fetches up to two data buffers and streams their bytes, lowest byte first, on a byte-wide valid/ready output. The output carries start and end-of-frame markers and a sideband request for checksum insertion. Finally the engine writes the first descriptor word back with the ownership flag cleared and moves on to the next descriptor.

A descriptor layout follows. Word 0 bit 31 is the ownership flag: 1 means the engine owns the descriptor. Word 1 carries the control bits and both buffer lengths. Word 2 is the first buffer address. Word 3 is either the second buffer address or the address of the next descriptor. The engine keeps processing descriptors until it reaches one it does not own, is told to stop, or receives a memory error. Each of these outcomes is reported in a status register that also drives the interrupt line.

Register map, by word index on `reg_addr`:
- 0: control, bit 0 = run.
- 1: ring base address, low 4 bits read as zero.
- 2: poll (write only).
- 3: status.
- 4: current descriptor address (read only).
- 5: current buffer address (read only).

Top module: `txdma_engine`

## Requirements
- R1: After reset, the status process state reads 0 (stopped), the current descriptor register reads 0, `irq` is low, `mem_req` is low and `tx_valid` is low.
- R2: Writing the control register with bit 0 set starts processing. If the current descriptor register is zero at that moment, it is first loaded from the base register. Descriptor words are then read from the current address, at offsets +0, +4, +8 and +12.
- R3: If word 0 bit 31 of a fetched descriptor is 0, the engine does the following and leaves the current descriptor register unchanged:
  - sets status bit 1;
  - enters process state 4 (suspended);
  - raises `irq`;
  - makes no further memory access and emits no byte.
- R4: Buffer 1 is read from the word 2 address with the length in word 1 bits 10:0. Unless word 1 bit 24 is set, buffer 2 is then read from the word 3 address with the length in bits 21:11. The bytes of both buffers are emitted in order, lowest address byte first. Buffer addresses are word aligned. Register 5 shows the address of the buffer most recently selected.
- R5: With word 1 bit 24 (chained) set, no second buffer is read, and word 3 is used as the next descriptor address.
- R6: Closing a descriptor writes word 0 back to the descriptor address. Bit 31 is cleared and all other bits are kept.
- R7: After a close, the next descriptor address is chosen in this order: the base register if word 1 bit 25 (end of ring) is set; otherwise word 3 if bit 24 is set; otherwise the current address + 16.
- R8: `tx_first` marks the first byte of a frame. `tx_last` marks the final byte of a descriptor only when word 1 bit 30 (last segment) is set. A frame may span several descriptors.
- R9: Word 1 bits 28:27 are latched only from a descriptor with bit 29 (first segment) set. `tx_csum` bit 0 is 1 when the latched field is above 0, and bit 1 is 1 when it is above 1. The value holds until the next first-segment descriptor.
- R10: When word 1 bit 31 is set, status bit 0 is set once that descriptor is closed, and `irq` rises.
- R11: Status reads as bit 0 transmit done, bit 1 unavailable, bit 2 bus error, and bits 6:4 process state (0 stopped, 1 fetching, 2 reading, 3 closing, 4 suspended). Writing 1 to any of bits 2:0 clears that bit, and `irq` is the OR of those three bits.
- R12: After closing one descriptor, the engine fetches the next one without any new command. A poll write restarts a suspended engine whatever value is written, but has no effect while control bit 0 is clear.
- R13: Clearing control bit 0 lets the current descriptor finish and close, after which the engine enters state 0 and fetches nothing more. A suspended engine goes to state 0 at once.
- R14: An error response on any memory access sets status bit 2 and puts the engine in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response strobe |
| mem_err | input | 1 | Response carries an error |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | First byte of frame |
| tx_last | output | 1 | Final byte of frame |
| tx_csum | output | 2 | Checksum insertion request |
| irq | output | 1 | Interrupt |

## Verification
The assertions check a set of local rules on every cycle:
- the stream holds a stalled byte stable;
- a memory request holds its address until it is acknowledged;
- descriptor accesses are word aligned;
- every write-back has the ownership bit clear;
- an engine in the stopped or suspended state issues no memory request;
- entering suspension raises the interrupt.

Whole-walk behaviour can only be shown by the bench scenarios, which run descriptor walks across a ring and compare against an independent model. These behaviours are:
- byte order across two buffers;
- frame markers over multi-descriptor frames;
- checksum latching;
- next-address priority;
- stop at a descriptor boundary;
- an ignored poll;
- recovery from a bus error.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    localparam int LEN_W    = 11;
    localparam int OWN_BIT  = 31;
    localparam int IOC_BIT  = 31;
    localparam int LS_BIT   = 30;
    localparam int FS_BIT   = 29;
    localparam int CS_LO    = 27;
    localparam int EOR_BIT  = 25;
    localparam int CH_BIT   = 24;
    localparam int DESC_BYTES = 16;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_BASE   = 3'd1;
    localparam logic [2:0] RA_POLL   = 3'd2;
    localparam logic [2:0] RA_STAT   = 3'd3;
    localparam logic [2:0] RA_CDESC  = 3'd4;
    localparam logic [2:0] RA_CBUF   = 3'd5;

    typedef enum logic [2:0] {
        PS_STOP  = 3'd0,
        PS_FETCH = 3'd1,
        PS_READ  = 3'd2,
        PS_CLOSE = 3'd3,
        PS_SUSP  = 3'd4
    } pstate_e;

    typedef enum logic [2:0] {
        ST_STOP, ST_SUSP, ST_DESC, ST_BUFRD, ST_EMIT, ST_CLOSE
    } fsm_e;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] cur_desc,
    input  logic [31:0] cur_buf,
    input  logic [2:0]  pstate,
    input  logic        set_ti,
    input  logic        set_tu,
    input  logic        set_fbe,
    output logic        run,
    output logic [31:0] base,
    output logic        kick,
    output logic        irq
);
    typedef struct packed {
        logic        run;
        logic [31:0] base;
        logic        ti;
        logic        tu;
        logic        fbe;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d    = q;
        kick = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_CTRL: begin
                    d.run = reg_wdata[0];
                    kick  = reg_wdata[0];
                end
                RA_BASE: d.base = {reg_wdata[31:4], 4'b0000};
                RA_POLL: kick = q.run;
                RA_STAT: begin
                    if (reg_wdata[0]) d.ti  = 1'b0;
                    if (reg_wdata[1]) d.tu  = 1'b0;
                    if (reg_wdata[2]) d.fbe = 1'b0;
                end
                default: ;
            endcase
        end
        if (set_ti)  d.ti  = 1'b1;
        if (set_tu)  d.tu  = 1'b1;
        if (set_fbe) d.fbe = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {31'd0, q.run};
            RA_BASE:  reg_rdata = q.base;
            RA_STAT:  reg_rdata = {25'd0, pstate, 1'b0, q.fbe, q.tu, q.ti};
            RA_CDESC: reg_rdata = cur_desc;
            RA_CBUF:  reg_rdata = cur_buf;
            default:  reg_rdata = 32'd0;
        endcase
    end

    assign run  = q.run;
    assign base = q.base;
    assign irq  = q.ti | q.tu | q.fbe;
endmodule

// File: rtl/txdma_serializer.sv
module txdma_serializer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_word,
    input  logic [2:0]  load_nbytes,
    input  logic        load_last,
    output logic        busy,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_first,
    output logic        tx_last
);
    typedef struct packed {
        logic        busy;
        logic [31:0] word;
        logic [2:0]  nb;
        logic [1:0]  idx;
        logic        last;
        logic        infr;
    } ser_t;

    ser_t q, d;
    logic [31:0] shifted;
    logic        final_byte;

    assign shifted    = q.word >> {q.idx, 3'b000};
    assign final_byte = ({1'b0, q.idx} == (q.nb - 3'd1));

    always_comb begin
        d = q;
        if (load) begin
            d.busy = 1'b1;
            d.word = load_word;
            d.nb   = load_nbytes;
            d.idx  = 2'd0;
            d.last = load_last;
        end else if (q.busy && tx_ready) begin
            d.infr = !(q.last && final_byte);
            if (final_byte) d.busy = 1'b0;
            else            d.idx  = q.idx + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign tx_valid = q.busy;
    assign tx_data  = shifted[7:0];
    assign tx_first = q.busy && !q.infr;
    assign tx_last  = q.busy && q.last && final_byte;
endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
    import txdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        kick,
    input  logic [31:0] base,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        ser_load,
    output logic [2:0]  ser_nbytes,
    output logic        ser_last,
    input  logic        ser_busy,
    output logic [1:0]  csum,
    output logic [31:0] cur_desc,
    output logic [31:0] cur_buf,
    output logic [2:0]  pstate,
    output logic        set_ti,
    output logic        set_tu,
    output logic        set_fbe
);
    typedef struct packed {
        fsm_e             st;
        logic [1:0]       widx;
        logic             req;
        logic             we;
        logic [31:0]      addr;
        logic [31:0]      wdata;
        logic [31:0]      w0;
        logic [31:0]      w1;
        logic [31:0]      w2;
        logic [31:0]      w3;
        logic [31:0]      cur;
        logic [31:0]      cbuf;
        logic [31:0]      baddr;
        logic             sel;
        logic [LEN_W-1:0] remain;
        logic [1:0]       csum;
    } walk_t;

    walk_t q, d;
    logic [LEN_W-1:0] len1, len2;
    logic [2:0]       nb;
    logic [1:0]       cs_field;

    assign len1     = q.w1[LEN_W-1:0];
    assign len2     = q.w1[2*LEN_W-1:LEN_W];
    assign nb       = (q.remain > LEN_W'(4)) ? 3'd4 : q.remain[2:0];
    assign cs_field = q.w1[CS_LO+1:CS_LO];

    always_comb begin
        d          = q;
        set_ti     = 1'b0;
        set_tu     = 1'b0;
        set_fbe    = 1'b0;
        ser_load   = 1'b0;
        ser_nbytes = nb;
        ser_last   = 1'b0;
        case (q.st)
            ST_STOP, ST_SUSP: begin
                if (q.st == ST_SUSP && !run) d.st = ST_STOP;
                if (kick) begin
                    d.st   = ST_DESC;
                    d.widx = 2'd0;
                    if (q.cur == 32'd0) d.cur = base;
                end
            end
            ST_DESC: begin
                if (!q.req) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = q.cur + {28'd0, q.widx, 2'b00};
                end else if (mem_ack) begin
                    d.req = 1'b0;
                    if (mem_err) begin
                        set_fbe = 1'b1;
                        d.st    = ST_STOP;
                    end else begin
                        case (q.widx)
                            2'd0: begin
                                if (!mem_rdata[OWN_BIT]) begin
                                    set_tu = 1'b1;
                                    d.st   = ST_SUSP;
                                end else begin
                                    d.w0   = mem_rdata;
                                    d.widx = 2'd1;
                                end
                            end
                            2'd1: begin
                                d.w1   = mem_rdata;
                                d.widx = 2'd2;
                            end
                            2'd2: begin
                                d.w2   = mem_rdata;
                                d.widx = 2'd3;
                            end
                            default: begin
                                d.w3     = mem_rdata;
                                d.sel    = 1'b0;
                                d.baddr  = q.w2;
                                d.cbuf   = q.w2;
                                d.remain = len1;
                                if (q.w1[FS_BIT])
                                    d.csum = {cs_field > 2'd1, cs_field != 2'd0};
                                d.st     = ST_BUFRD;
                            end
                        endcase
                    end
                end
            end
            ST_BUFRD: begin
                if (q.remain == '0) begin
                    if (!q.sel && !q.w1[CH_BIT]) begin
                        d.sel    = 1'b1;
                        d.baddr  = q.w3;
                        d.cbuf   = q.w3;
                        d.remain = len2;
                    end else begin
                        d.st = ST_CLOSE;
                    end
                end else if (!q.req) begin
                    d.req  = 1'b1;
                    d.we   = 1'b0;
                    d.addr = {q.baddr[31:2], 2'b00};
                end else if (mem_ack) begin
                    d.req = 1'b0;
                    if (mem_err) begin
                        set_fbe = 1'b1;
                        d.st    = ST_STOP;
                    end else begin
                        ser_load = 1'b1;
                        ser_last = q.w1[LS_BIT] && (q.remain <= LEN_W'(4)) &&
                                   (q.sel || q.w1[CH_BIT] || len2 == '0);
                        d.remain = q.remain - LEN_W'(nb);
                        d.baddr  = q.baddr + 32'd4;
                        d.st     = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (!ser_busy) d.st = ST_BUFRD;
            end
            ST_CLOSE: begin
                if (!q.req) begin
                    d.req   = 1'b1;
                    d.we    = 1'b1;
                    d.addr  = q.cur;
                    d.wdata = q.w0 & ~(32'd1 << OWN_BIT);
                end else if (mem_ack) begin
                    d.req = 1'b0;
                    d.we  = 1'b0;
                    if (mem_err) begin
                        set_fbe = 1'b1;
                        d.st    = ST_STOP;
                    end else begin
                        set_ti = q.w1[IOC_BIT];
                        if (q.w1[EOR_BIT])     d.cur = base;
                        else if (q.w1[CH_BIT]) d.cur = q.w3;
                        else                   d.cur = q.cur + 32'(DESC_BYTES);
                        d.widx = 2'd0;
                        d.st   = run ? ST_DESC : ST_STOP;
                    end
                end
            end
            default: d.st = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_STOP;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_DESC:           pstate = PS_FETCH;
            ST_BUFRD, ST_EMIT: pstate = PS_READ;
            ST_CLOSE:          pstate = PS_CLOSE;
            ST_SUSP:           pstate = PS_SUSP;
            default:           pstate = PS_STOP;
        endcase
    end

    assign mem_req   = q.req;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign csum      = q.csum;
    assign cur_desc  = q.cur;
    assign cur_buf   = q.cbuf;
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_first,
    output logic        tx_last,
    output logic [1:0]  tx_csum,
    output logic        irq
);
    logic        run, kick, set_ti, set_tu, set_fbe;
    logic [31:0] base, cur_desc, cur_buf;
    logic [2:0]  pstate;
    logic        ser_load, ser_last, ser_busy;
    logic [2:0]  ser_nbytes;

    txdma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cur_desc(cur_desc), .cur_buf(cur_buf), .pstate(pstate),
        .set_ti(set_ti), .set_tu(set_tu), .set_fbe(set_fbe),
        .run(run), .base(base), .kick(kick), .irq(irq)
    );

    txdma_walker u_walk (
        .clk(clk), .rst_n(rst_n), .run(run), .kick(kick), .base(base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .ser_load(ser_load), .ser_nbytes(ser_nbytes), .ser_last(ser_last), .ser_busy(ser_busy),
        .csum(tx_csum), .cur_desc(cur_desc), .cur_buf(cur_buf), .pstate(pstate),
        .set_ti(set_ti), .set_tu(set_tu), .set_fbe(set_fbe)
    );

    txdma_serializer u_ser (
        .clk(clk), .rst_n(rst_n),
        .load(ser_load), .load_word(mem_rdata), .load_nbytes(ser_nbytes), .load_last(ser_last),
        .busy(ser_busy),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last)
    );
endmodule

// File: rtl/txdma_engine_chk.sv
module txdma_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic [2:0]  pstate,
    input logic        irq
);
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_writeback_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    assert_desc_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && pstate == 3'd1 |-> mem_addr[1:0] == 2'b00);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 3'd0 || pstate == 3'd4) |-> !mem_req);

    assert_susp_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstate == 3'd4) |-> irq);
endmodule

bind txdma_engine txdma_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .pstate(pstate), .irq(irq)
);

// File: tb/txdma_engine_test.sv
`timescale 1ns/1ps
module txdma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        tx_valid, tx_ready = 1'b0, tx_first, tx_last, irq;
    logic [7:0]  tx_data;
    logic [1:0]  tx_csum;

    always #2.5 clk = ~clk;

    txdma_engine uut (.*);

    logic [31:0] mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          vectors = 0, fails = 0, cyc = 0;
    int          exp_q[$];
    logic [63:0] expw_q[$];
    logic [31:0] m_cur = 0, m_cbuf = 0, m_base = 0;
    bit          m_infr = 0, m_ti = 0, m_tu = 0, m_fbe = 0;
    logic [1:0]  m_cs = 0;
    int          m_state = 0;
    logic [31:0] shadow [0:1023];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder, stream sampler
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_ready = !((cyc % 5) == 1 || (cyc % 7) == 3);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                mem_ack = 1'b1;
                mem_err = (mem_addr == err_addr) && !mem_we;
                if (mem_we) begin
                    if (expw_q.size() == 0)
                        chk(0, "R6 unexpected write", mem_addr, 32'hx);
                    else begin
                        logic [63:0] e;
                        e = expw_q.pop_front();
                        chk(mem_addr == e[63:32], "R7 writeback address", mem_addr, e[63:32]);
                        chk(mem_wdata == e[31:0], "R6 writeback data", mem_wdata, e[31:0]);
                    end
                    mem[mem_addr[11:2]] = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                end
            end
            #1;
            if (tx_valid && tx_ready) begin
                int act;
                act = {20'd0, tx_csum, tx_first, tx_last, tx_data};
                if (exp_q.size() == 0)
                    chk(0, "R4 unexpected byte", act, 32'hx);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(act == e, "R4/R8/R9 stream byte", act, e);
                end
            end
        end
    end

    task automatic push_buf(input logic [31:0] a, input int len, inout int bytes[$]);
        for (int i = 0; i < len; i++) begin
            logic [31:0] w;
            w = shadow[(a >> 2) + (i >> 2)];
            bytes.push_back(int'((w >> (8 * (i & 3))) & 32'hFF));
        end
    endtask

    // behavioural walk of the descriptor list
    task automatic model_walk(input int maxd);
        logic [31:0] a, w0, w1, w2, w3;
        for (int i = 0; i < 1024; i++) shadow[i] = mem[i];
        a = (m_cur == 0) ? m_base : m_cur;
        for (int k = 0; k < maxd; k++) begin
            int bytes[$];
            int l1, l2;
            w0 = shadow[a >> 2]; w1 = shadow[(a >> 2) + 1];
            w2 = shadow[(a >> 2) + 2]; w3 = shadow[(a >> 2) + 3];
            if (!w0[31]) begin
                m_tu = 1; m_state = 4; m_cur = a;
                return;
            end
            l1 = int'(w1[10:0]); l2 = int'(w1[21:11]);
            if (w1[29]) m_cs = {w1[28:27] > 2'd1, w1[28:27] != 2'd0};
            m_cbuf = w2;
            if (l1 > 0 && w2 == err_addr) begin
                m_fbe = 1; m_state = 0; m_cur = a;
                return;
            end
            push_buf(w2, l1, bytes);
            if (!w1[24]) begin
                m_cbuf = w3;
                push_buf(w3, l2, bytes);
            end
            foreach (bytes[j]) begin
                bit f, l;
                f = (j == 0) && !m_infr;
                l = w1[30] && (j == bytes.size() - 1);
                exp_q.push_back({20'd0, m_cs, f, l, bytes[j][7:0]});
            end
            if (bytes.size() > 0) m_infr = !w1[30];
            shadow[a >> 2] = w0 & 32'h7FFF_FFFF;
            expw_q.push_back({a, w0 & 32'h7FFF_FFFF});
            if (w1[31]) m_ti = 1;
            if (w1[25])      a = m_base;
            else if (w1[24]) a = w3;
            else             a = a + 16;
        end
        m_cur = a; m_state = 0;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            reg_read(3'd3, s);
            if ((s[6:4] == 3'd0 || s[6:4] == 3'd4) && exp_q.size() == 0 && !mem_req) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_status(input string req);
        logic [31:0] s, c, b;
        reg_read(3'd3, s);
        reg_read(3'd4, c);
        reg_read(3'd5, b);
        chk(s[6:0] == {3'(m_state), 1'b0, m_fbe, m_tu, m_ti}, {req, " status"}, s,
            {25'd0, 3'(m_state), 1'b0, m_fbe, m_tu, m_ti});
        chk(c == m_cur, {req, " current descriptor"}, c, m_cur);
        chk(b == m_cbuf, "R4 current buffer", b, m_cbuf);
        chk(irq == (m_ti | m_tu | m_fbe), "R11 irq", {31'd0, irq}, {31'd0, m_ti | m_tu | m_fbe});
        chk(exp_q.size() == 0, "R8 missing bytes", exp_q.size(), 0);
    endtask

    initial begin
        logic [31:0] s;
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0107_0B0D) ^ 32'hA5C3_5A3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_read(3'd3, s);
        chk(s == 32'd0, "R1 status after reset", s, 0);
        reg_read(3'd4, s);
        chk(s == 32'd0, "R1 current descriptor after reset", s, 0);
        chk(!irq && !mem_req && !tx_valid, "R1 outputs idle", {29'd0, irq, mem_req, tx_valid}, 0);

        // R2 R4 R5 R7 R8 R9 R10 R12: ring of three with chain and wrap
        mem[32'h100 >> 2] = 32'h8000_0000;
        mem[(32'h100 >> 2) + 1] = (32'd1 << 29) | (32'd3 << 27) | (32'd3 << 11) | 32'd5;
        mem[(32'h100 >> 2) + 2] = 32'h400;
        mem[(32'h100 >> 2) + 3] = 32'h500;
        mem[32'h110 >> 2] = 32'h8000_0055;
        mem[(32'h110 >> 2) + 1] = (32'd1 << 31) | (32'd1 << 30) | (32'd1 << 24) | 32'd6;
        mem[(32'h110 >> 2) + 2] = 32'h480;
        mem[(32'h110 >> 2) + 3] = 32'h200;
        mem[32'h200 >> 2] = 32'h8000_0000;
        mem[(32'h200 >> 2) + 1] = (32'd1 << 30) | (32'd1 << 29) | (32'd1 << 25) | (32'd1 << 27) | 32'd4;
        mem[(32'h200 >> 2) + 2] = 32'h520;
        mem[(32'h200 >> 2) + 3] = 32'h600;
        reg_write(3'd1, 32'h0000_0107);
        m_base = 32'h100;
        reg_read(3'd1, s);
        chk(s == 32'h100, "R2 base low bits cleared", s, 32'h100);
        model_walk(16);
        reg_write(3'd0, 32'd1);
        wait_idle();
        check_status("R3/R10/R12 ring walk");
        chk(expw_q.size() == 0, "R6 write-backs done", expw_q.size(), 0);

        // R11 write-one-to-clear
        reg_write(3'd3, 32'h7);
        m_ti = 0; m_tu = 0;
        check_status("R11 clear");

        // R13 stop from suspended, R12 poll ignored while stopped
        reg_write(3'd0, 32'd0);
        m_state = 0;
        mem[32'h100 >> 2] = 32'h8000_0000;
        mem[(32'h100 >> 2) + 1] = (32'd1 << 30) | (32'd1 << 29) | (32'd7 << 11) | 32'd2;
        mem[(32'h100 >> 2) + 2] = 32'h400;
        mem[(32'h100 >> 2) + 3] = 32'h700;
        mem[32'h110 >> 2] = 32'h0000_0000;
        reg_write(3'd2, 32'h0);
        repeat (30) @(negedge clk);
        check_status("R13 stopped after run clear");
        chk(mem[32'h100 >> 2][31] == 1'b1, "R12 poll ignored while stopped",
            mem[32'h100 >> 2], 32'h8000_0000);

        // R7 sequential advance, R4 two buffers, suspend at +16
        model_walk(16);
        reg_write(3'd0, 32'd1);
        wait_idle();
        check_status("R7 advance by 16");

        // R13 stop lets current descriptor finish; R12 poll restarts from suspend
        mem[32'h110 >> 2] = 32'h8000_0000;
        mem[(32'h110 >> 2) + 1] = (32'd1 << 30) | (32'd1 << 29) | (32'd2 << 27) | 32'd9;
        mem[(32'h110 >> 2) + 2] = 32'h800;
        mem[(32'h110 >> 2) + 3] = 32'h0;
        mem[32'h120 >> 2] = 32'h8000_0000;
        mem[(32'h120 >> 2) + 1] = (32'd1 << 30) | (32'd1 << 29) | 32'd4;
        mem[(32'h120 >> 2) + 2] = 32'h900;
        mem[(32'h120 >> 2) + 3] = 32'h0;
        m_tu = 1;
        model_walk(1);
        reg_write(3'd2, 32'h1234_5678);
        repeat (4) @(negedge clk);
        reg_write(3'd0, 32'd0);
        wait_idle();
        check_status("R13 stop at boundary");
        chk(mem[32'h120 >> 2][31] == 1'b1, "R13 next descriptor untouched",
            mem[32'h120 >> 2], 32'h8000_0000);

        // R14 bus error on buffer read
        reg_write(3'd3, 32'h7);
        m_tu = 0;
        err_addr = 32'h900;
        model_walk(16);
        reg_write(3'd0, 32'd1);
        wait_idle();
        check_status("R14 bus error");
        chk(mem[32'h120 >> 2][31] == 1'b1, "R14 no write-back after error",
            mem[32'h120 >> 2], 32'h8000_0000);
        chk(expw_q.size() == 0, "R6 all write-backs seen", expw_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule